// File: doc/BRIEF.md
# Packed Subword Integer Multiply-Accumulate

This block is the integer multiply-accumulate datapath of a media signal-processing engine. Each cycle it takes two 32-bit operand words and splits them into four 8-bit lanes, two 16-bit lanes or one 32-bit lane, as the mode input selects. It multiplies matching lanes of the two words and adds each product into that lane's own accumulator. One control bit sets the lane format for both operands. When it is set, the lanes are two's-complement. When it is clear, they are unsigned.

A valid strobe qualifies each operand pair. A clear bit starts a new sum by loading the accumulator with the current product instead of adding to it. There is one register stage, so results and the result-valid flag appear one cycle after the inputs. Accumulators are wider than the products and wrap silently. The lane format or signedness may only change on a cycle that also clears. Otherwise the accumulator content is undefined.

Top module: `subword_mac`

## Requirements
- R1: `mode_i` picks the lane format: 0 is four 8-bit lanes (lane k is operand bits 8k+7..8k), 1 is two 16-bit lanes (lane k is bits 16k+15..16k), 2 is one 32-bit lane. Value 3 is reserved and is never driven.
- R2: `acc_o` layout: in 8-bit mode lane k accumulates in bits 24k+23..24k. In 16-bit mode lane k uses bits 40k+39..40k and bits 95..80 read zero. In 32-bit mode the lane uses bits 71..0 and bits 95..72 read zero. This holds after any valid cycle with `clr_i` high.
- R3: When `sgn_i`=1, both operand lanes are two's-complement. When `sgn_i`=0, both are unsigned. The product is extended to the accumulator width with matching signedness.
- R4: A valid cycle with `clr_i`=1 loads each lane accumulator with that cycle's lane product.
- R5: A valid cycle with `clr_i`=0 adds each lane product to that lane's accumulator modulo 2^24, 2^40 or 2^72. No carry crosses into a neighbouring lane.
- R6: `vld_o` equals `in_vld_i` from the previous cycle, and `acc_o` reflects that cycle's operands.
- R7: While `in_vld_i`=0, `acc_o` holds its value whatever the other inputs do.
- R8: While `rst_n` is low, `acc_o` is zero and `vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Operand pair valid |
| clr_i | input | 1 | Load product instead of accumulating |
| mode_i | input | 2 | Lane format (0: 4x8, 1: 2x16, 2: 1x32) |
| sgn_i | input | 1 | 1: signed lanes, 0: unsigned lanes |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| acc_o | output | 96 | Packed lane accumulators |
| vld_o | output | 1 | Result valid, one cycle after `in_vld_i` |

## Verification
The assertions assume that `mode_i` is never 3. They also assume that the lane format and signedness change only on a valid cycle that also clears. The zero-field and lane-result properties are therefore tied to clearing cycles. The stimulus respects these limits. Every test phase opens with a forced valid clearing cycle, and mode and signedness stay fixed inside a phase. Mode and signedness vary freely only while the valid strobe is low, where they cannot reach the accumulators.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int WORD_W   = 32;
  localparam int LANE8_W  = 8;
  localparam int LANE16_W = 16;
  localparam int ACC8_W   = 24;
  localparam int ACC16_W  = 40;
  localparam int ACC32_W  = 72;
  localparam int N8       = WORD_W / LANE8_W;
  localparam int N16      = WORD_W / LANE16_W;
  localparam int OUT_W    = N8 * ACC8_W;

  typedef enum logic [1:0] {
    MODE_Q8  = 2'd0,
    MODE_H16 = 2'd1,
    MODE_W32 = 2'd2
  } mode_e;
endpackage

// File: rtl/smac_lane_mul.sv
module smac_lane_mul #(
  parameter int LW = 8,
  parameter int AW = 24
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sgn_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2 * LW + 2;

  logic signed [LW:0]   ax, bx;
  logic signed [PW-1:0] full;

  // one extra bit per operand turns both signednesses into one signed multiply
  assign ax   = {sgn_i & a_i[LW-1], a_i};
  assign bx   = {sgn_i & b_i[LW-1], b_i};
  assign full = PW'(ax) * PW'(bx);
  assign prod_o = {{(AW - PW){full[PW-1]}}, full};
endmodule

// File: rtl/smac_mul_array.sv
module smac_mul_array
  import smac_pkg::*;
(
  input  mode_e             mode_i,
  input  logic              sgn_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [OUT_W-1:0]  prod_o
);
  logic [OUT_W-1:0] p8, p16, p32;

  for (genvar g = 0; g < N8; g++) begin : g_q8
    smac_lane_mul #(.LW(LANE8_W), .AW(ACC8_W)) u_mul (
      .a_i   (a_i[g*LANE8_W +: LANE8_W]),
      .b_i   (b_i[g*LANE8_W +: LANE8_W]),
      .sgn_i (sgn_i),
      .prod_o(p8[g*ACC8_W +: ACC8_W])
    );
  end

  for (genvar g = 0; g < N16; g++) begin : g_h16
    smac_lane_mul #(.LW(LANE16_W), .AW(ACC16_W)) u_mul (
      .a_i   (a_i[g*LANE16_W +: LANE16_W]),
      .b_i   (b_i[g*LANE16_W +: LANE16_W]),
      .sgn_i (sgn_i),
      .prod_o(p16[g*ACC16_W +: ACC16_W])
    );
  end
  assign p16[OUT_W-1:N16*ACC16_W] = '0;

  smac_lane_mul #(.LW(WORD_W), .AW(ACC32_W)) u_mul_w32 (
    .a_i   (a_i),
    .b_i   (b_i),
    .sgn_i (sgn_i),
    .prod_o(p32[ACC32_W-1:0])
  );
  assign p32[OUT_W-1:ACC32_W] = '0;

  always_comb begin
    case (mode_i)
      MODE_Q8:  prod_o = p8;
      MODE_H16: prod_o = p16;
      default:  prod_o = p32;
    endcase
  end
endmodule

// File: rtl/smac_acc_bank.sv
module smac_acc_bank
  import smac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  mode_e            mode_i,
  input  logic [OUT_W-1:0] prod_i,
  output logic [OUT_W-1:0] acc_o
);
  logic [OUT_W-1:0] acc_q, acc_d, base;

  // next-state: lane-sized adders, so carries stop at lane edges
  always_comb begin
    base  = clr_i ? '0 : acc_q;
    acc_d = '0;
    case (mode_i)
      MODE_Q8: begin
        for (int i = 0; i < N8; i++)
          acc_d[i*ACC8_W +: ACC8_W] = base[i*ACC8_W +: ACC8_W] + prod_i[i*ACC8_W +: ACC8_W];
      end
      MODE_H16: begin
        for (int j = 0; j < N16; j++)
          acc_d[j*ACC16_W +: ACC16_W] = base[j*ACC16_W +: ACC16_W] + prod_i[j*ACC16_W +: ACC16_W];
      end
      default: acc_d[ACC32_W-1:0] = base[ACC32_W-1:0] + prod_i[ACC32_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_q));

  // R2
  h16_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i && mode_i == MODE_H16) |=> (acc_q[OUT_W-1:N16*ACC16_W] == '0));

  // R2
  w32_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i && mode_i == MODE_W32) |=> (acc_q[OUT_W-1:ACC32_W] == '0));
endmodule

// File: rtl/subword_mac.sv
module subword_mac
  import smac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld_i,
  input  logic              clr_i,
  input  logic [1:0]        mode_i,
  input  logic              sgn_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [OUT_W-1:0]  acc_o,
  output logic              vld_o
);
  mode_e            mode;
  logic [OUT_W-1:0] prod;
  logic             vld_q;

  assign mode = mode_e'(mode_i);

  smac_mul_array u_mul (
    .mode_i(mode),
    .sgn_i (sgn_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  smac_acc_bank u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (in_vld_i),
    .clr_i (clr_i),
    .mode_i(mode),
    .prod_i(prod),
    .acc_o (acc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld_i;
  end

  assign vld_o = vld_q;

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |-> (mode_i != 2'd3));

  // R6
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == $past(in_vld_i));

  // R4
  clr_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && clr_i && mode_i == 2'd0 && !sgn_i) |=>
      (acc_o[ACC8_W-1:0] == ACC8_W'($past(a_i[LANE8_W-1:0])) * ACC8_W'($past(b_i[LANE8_W-1:0]))));
endmodule

// File: tb/subword_mac_bench.sv
`timescale 1ns/1ps
module subword_mac_bench;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, clr, sgn;
  logic [1:0]  mode;
  logic [31:0] a, b;
  logic [95:0] acc;
  logic        vld;

  int    checks = 0;
  int    failures = 0;
  string tag = "R8";

  logic [95:0] exp_acc = '0;
  logic        exp_vld = 1'b0;

  always #(CYC/2) clk = ~clk;

  subword_mac u_subword_mac (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .clr_i(clr), .mode_i(mode),
    .sgn_i(sgn), .a_i(a), .b_i(b), .acc_o(acc), .vld_o(vld)
  );

  function automatic logic [95:0] ref_step(logic [95:0] old, logic [1:0] m, logic s,
                                           logic c, logic [31:0] x, logic [31:0] y);
    int n  = (m == 2'd0) ? 4 : (m == 2'd1) ? 2 : 1;
    int lw = 32 / n;
    int aw = (m == 2'd0) ? 24 : (m == 2'd1) ? 40 : 72;
    logic [95:0] res  = '0;
    logic [95:0] mask = (96'd1 << aw) - 96'd1;
    for (int k = 0; k < n; k++) begin
      logic signed [79:0] xv, yv, pv;
      logic [95:0] pe, prev;
      xv = 80'((x >> (k * lw)) & ((33'd1 << lw) - 33'd1));
      yv = 80'((y >> (k * lw)) & ((33'd1 << lw) - 33'd1));
      if (s && xv[lw-1]) xv = xv - (80'sd1 <<< lw);
      if (s && yv[lw-1]) yv = yv - (80'sd1 <<< lw);
      pv   = xv * yv;
      pe   = 96'(pv);
      prev = c ? 96'd0 : ((old >> (k * aw)) & mask);
      res  = res | (((prev + pe) & mask) << (k * aw));
    end
    return res;
  endfunction

  task automatic compare();
    checks++;
    if (acc !== exp_acc) begin
      failures++;
      $display("FAIL %s acc actual=%h expected=%h", tag, acc, exp_acc);
    end
    checks++;
    if (vld !== exp_vld) begin
      failures++;
      $display("FAIL %s R6 vld actual=%b expected=%b", tag, vld, exp_vld);
    end
  endtask

  // one clock: check last result, drive new inputs, advance the model
  task automatic cyc(logic v, logic c, logic [1:0] m, logic s, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    compare();
    in_vld = v; clr = c; mode = m; sgn = s; a = x; b = y;
    if (v) exp_acc = ref_step(exp_acc, m, s, c, x, y);
    exp_vld = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; clr = 1'b0; mode = 2'd0; sgn = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    // R8: reset state
    @(negedge clk);
    tag = "R8";
    compare();
    rst_n = 1'b1;

    // R4: clear loads product, signed 8-bit corners
    tag = "R4";
    cyc(1, 1, 2'd0, 1, 32'h80FF7F01, 32'h80FF8102);
    cyc(1, 1, 2'd0, 0, 32'h80FF7F01, 32'h80FF8102);
    cyc(1, 1, 2'd1, 1, 32'h80007FFF, 32'h80008000);
    cyc(1, 1, 2'd2, 1, 32'h80000000, 32'h80000000);

    // R5: long accumulation wraps inside each lane
    tag = "R5";
    cyc(1, 1, 2'd0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    for (int i = 0; i < 300; i++) cyc(1, 0, 2'd0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cyc(1, 1, 2'd1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    for (int i = 0; i < 300; i++) cyc(1, 0, 2'd1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cyc(1, 1, 2'd2, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    for (int i = 0; i < 300; i++) cyc(1, 0, 2'd2, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cyc(1, 1, 2'd0, 1, 32'h80808080, 32'h80808080);
    for (int i = 0; i < 300; i++) cyc(1, 0, 2'd0, 1, 32'h80808080, 32'h80808080);

    // R1 R2 R3: random operands in every mode and signedness
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        tag = "R1 R2 R3";
        cyc(1, 1, 2'(m), 1'(s), $urandom, $urandom);
        for (int i = 0; i < 200; i++)
          cyc(($urandom % 4) != 0, ($urandom % 10) == 0, 2'(m), 1'(s), $urandom, $urandom);
      end
    end

    // R7: idle cycles with busy inputs leave accumulators unchanged
    tag = "R7";
    cyc(1, 1, 2'd1, 1, $urandom, $urandom);
    for (int i = 0; i < 40; i++)
      cyc(0, 1'($urandom), 2'($urandom % 3), 1'($urandom), $urandom, $urandom);

    // R6: alternating valid strobe
    tag = "R6";
    cyc(1, 1, 2'd2, 0, $urandom, $urandom);
    for (int i = 0; i < 40; i++) cyc(1'(i % 2), 0, 2'd2, 0, $urandom, $urandom);
    cyc(0, 0, 2'd2, 0, 32'd0, 32'd0);
    @(negedge clk);
    compare();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule